// File: doc/BRIEF.md
# Checkpointed Register Rename Map

This block is the register alias table of a four-wide out-of-order core. It maps 32 architectural registers onto 128 physical registers and is held as a flop array. Each cycle it looks up the physical names of two source operands for each of four instructions in a rename group. It then writes the new destination names that the free list supplied into the current map. Sources that name a destination written by an older slot of the same group take that slot's new physical register.

A group may end with a branch. When it does, the block copies the whole map into a checkpoint slot in the same cycle, as that map stands after the group's writes, and stores the branch's alternative fetch PC beside it. The branch gets a 2-bit tag. A mispredict on a tag reverts the current map to that snapshot in one cycle, discards every younger snapshot and presents the alternative PC for a fetch redirect. A commit of the oldest tag promotes its snapshot to the committed map and frees the slot. While four snapshots are held the block raises a stall and ignores incoming groups.

Occupancy of the checkpoint stack is tracked by a three-state machine. `CK_EMPTY` holds no snapshot. `CK_OPEN` holds one to three. `CK_FULL` holds four and drives the stall. A push moves `CK_EMPTY` to `CK_OPEN` and the fourth push moves `CK_OPEN` to `CK_FULL`. A commit or mispredict that leaves fewer than four moves `CK_FULL` back to `CK_OPEN`, and a commit of the last held snapshot moves `CK_OPEN` to `CK_EMPTY`.

Top module: `rat_rename_map`

## Requirements
- R1: After reset each architectural register Rn maps to physical Pn in both the current and committed maps, no checkpoint is held, `stall` is 0 and `br_tag` is 0.
- R2: `src_a_phys`/`src_b_phys` slot i (7-bit field at bits i*7) give the current mapping of the 5-bit source at bits i*5, except that a valid destination of an older slot j<i in the same group with the same architectural index supplies its new physical register (the youngest such j wins).
- R3: An accepted group writes each valid destination with a nonzero architectural index into the current map at the clock edge; when two slots name the same register the higher slot wins.
- R4: An accepted group with `ren_branch` set stores the map after the group's writes, with `ren_alt_pc`, in the slot named by `br_tag`; tags are handed out in order 0,1,2,3,0,...
- R5: While four checkpoints are held, `stall` is 1 and a rename group changes neither the map nor the checkpoint stack.
- R6: With `mis_valid`, `redirect_valid` is 1 and `redirect_pc` is the saved alternative PC of `mis_tag` in the same cycle. From the next cycle the current map equals that tag's snapshot, and younger checkpoints are released, so the next tag is `mis_tag`+1.
- R7: `cmt_valid` with the oldest held tag copies that snapshot into the committed map, visible through `cmt_lookup_arch`/`cmt_lookup_phys` from the next cycle, and releases the slot.
- R8: A rename group arriving together with `mis_valid` is dropped: no map write and no checkpoint.
- R9: Architectural register 0 always reads physical 0 and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 4 | Slot holds an instruction |
| ren_src_a | input | 20 | First source index per slot, 5 bits each |
| ren_src_b | input | 20 | Second source index per slot |
| ren_dst_valid | input | 4 | Slot writes a destination |
| ren_dst_arch | input | 20 | Destination architectural index per slot |
| ren_dst_phys | input | 28 | New physical register per slot, 7 bits each |
| ren_branch | input | 1 | Group ends with a branch; take a checkpoint |
| ren_alt_pc | input | 32 | Alternative fetch PC of that branch |
| src_a_phys | output | 28 | Renamed first sources |
| src_b_phys | output | 28 | Renamed second sources |
| br_tag | output | 2 | Tag the next checkpoint will receive |
| stall | output | 1 | Checkpoint stack full; group ignored |
| mis_valid | input | 1 | Branch mispredicted |
| mis_tag | input | 2 | Tag of the mispredicted branch |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Redirect target |
| cmt_valid | input | 1 | Oldest branch commits |
| cmt_tag | input | 2 | Tag of the committing branch |
| cmt_lookup_arch | input | 5 | Committed-map lookup index |
| cmt_lookup_phys | output | 7 | Committed-map lookup result |

## Verification
The checker relies on the environment naming only held tags: a commit always carries the oldest live tag and a mispredict carries a live tag. A commit never names the same branch as a same-cycle mispredict, and at most one branch is checkpointed per group. The directed bench keeps within this by tracking which tags it has been given and which it has retired, and by committing strictly in allocation order. It also drives a mispredict only on a tag still held.

// File: rtl/rat_pkg.sv
package rat_pkg;
    localparam int ARCH_REGS = 32;
    localparam int PHYS_REGS = 128;
    localparam int GROUP_W   = 4;
    localparam int CKPT_N    = 4;   // power of two: tags wrap naturally
    localparam int PC_W      = 32;

    localparam int AREG_W = $clog2(ARCH_REGS);
    localparam int PREG_W = $clog2(PHYS_REGS);
    localparam int TAG_W  = $clog2(CKPT_N);
    localparam int CNT_W  = $clog2(CKPT_N + 1);

    typedef logic [AREG_W-1:0]     areg_t;
    typedef logic [PREG_W-1:0]     preg_t;
    typedef logic [TAG_W-1:0]      tag_t;
    typedef logic [CNT_W-1:0]      cnt_t;
    typedef preg_t [ARCH_REGS-1:0] map_t;

    typedef enum logic [1:0] {
        CK_EMPTY,
        CK_OPEN,
        CK_FULL
    } ck_state_e;
endpackage

// File: rtl/rat_map_table.sv
module rat_map_table
    import rat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GROUP_W-1:0]   byp_en,
    input  logic [GROUP_W-1:0]   wr_en,
    input  areg_t [GROUP_W-1:0]  dst_arch,
    input  preg_t [GROUP_W-1:0]  dst_phys,
    input  areg_t [GROUP_W-1:0]  src_a,
    input  areg_t [GROUP_W-1:0]  src_b,
    output preg_t [GROUP_W-1:0]  phys_a,
    output preg_t [GROUP_W-1:0]  phys_b,
    input  logic                 restore_en,
    input  map_t                 restore_map,
    output map_t                 map_after
);
    map_t cur_map;

    // Map as it stands after this group's writes, in program order.
    always_comb begin
        map_after = cur_map;
        for (int i = 0; i < GROUP_W; i++) begin
            if (wr_en[i]) map_after[dst_arch[i]] = dst_phys[i];
        end
    end

    // Lookup with intra-group dependence override.
    always_comb begin
        for (int i = 0; i < GROUP_W; i++) begin
            phys_a[i] = cur_map[src_a[i]];
            phys_b[i] = cur_map[src_b[i]];
            for (int j = 0; j < i; j++) begin
                if (byp_en[j] && dst_arch[j] == src_a[i]) phys_a[i] = dst_phys[j];
                if (byp_en[j] && dst_arch[j] == src_b[i]) phys_b[i] = dst_phys[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ARCH_REGS; k++) cur_map[k] <= PREG_W'(k);
        end else if (restore_en) begin
            cur_map <= restore_map;
        end else begin
            cur_map <= map_after;
        end
    end
endmodule

// File: rtl/rat_ckpt_stack.sv
module rat_ckpt_stack
    import rat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  map_t            push_map,
    input  logic [PC_W-1:0] push_pc,
    input  logic            mis_valid,
    input  tag_t            mis_tag,
    input  logic            cmt_valid,
    input  tag_t            cmt_tag,
    input  areg_t           cmt_arch,
    output preg_t           cmt_phys,
    output map_t            restore_map,
    output logic [PC_W-1:0] redirect_pc,
    output tag_t            alloc_tag,
    output logic            full,
    output cnt_t            count_o,
    output tag_t            head_o
);
    map_t              snap    [CKPT_N];
    logic [PC_W-1:0]   snap_pc [CKPT_N];
    map_t              cmt_map;
    tag_t              head, tail, tail_next, head_next;
    cnt_t              count, count_next;
    ck_state_e         state, state_next;

    assign restore_map = snap[mis_tag];
    assign redirect_pc = snap_pc[mis_tag];
    assign cmt_phys    = cmt_map[cmt_arch];
    assign alloc_tag   = tail;
    assign count_o     = count;
    assign head_o      = head;

    // Pointer and occupancy update.
    always_comb begin
        head_next = head + tag_t'(cmt_valid);
        if (mis_valid) begin
            tail_next  = mis_tag + tag_t'(1);
            count_next = cnt_t'(tag_t'(mis_tag - head)) + cnt_t'(1) - cnt_t'(cmt_valid);
        end else begin
            tail_next  = tail + tag_t'(push);
            count_next = count + cnt_t'(push) - cnt_t'(cmt_valid);
        end
        if (count_next == '0)                 state_next = CK_EMPTY;
        else if (count_next == cnt_t'(CKPT_N)) state_next = CK_FULL;
        else                                  state_next = CK_OPEN;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CK_EMPTY;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            state <= state_next;
            head  <= head_next;
            tail  <= tail_next;
            count <= count_next;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        unique case (state)
            CK_EMPTY: full = 1'b0;
            CK_OPEN:  full = 1'b0;
            CK_FULL:  full = 1'b1;
            default:  full = 1'b0;
        endcase
    end

    // Snapshot storage.
    always_ff @(posedge clk) begin
        if (push) begin
            snap[tail]    <= push_map;
            snap_pc[tail] <= push_pc;
        end
    end

    // Committed map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ARCH_REGS; k++) cmt_map[k] <= PREG_W'(k);
        end else if (cmt_valid) begin
            cmt_map <= snap[cmt_tag];
        end
    end
endmodule

// File: rtl/rat_rename_map.sv
module rat_rename_map
    import rat_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [GROUP_W-1:0]           ren_valid,
    input  logic [GROUP_W*AREG_W-1:0]    ren_src_a,
    input  logic [GROUP_W*AREG_W-1:0]    ren_src_b,
    input  logic [GROUP_W-1:0]           ren_dst_valid,
    input  logic [GROUP_W*AREG_W-1:0]    ren_dst_arch,
    input  logic [GROUP_W*PREG_W-1:0]    ren_dst_phys,
    input  logic                         ren_branch,
    input  logic [PC_W-1:0]              ren_alt_pc,
    output logic [GROUP_W*PREG_W-1:0]    src_a_phys,
    output logic [GROUP_W*PREG_W-1:0]    src_b_phys,
    output logic [TAG_W-1:0]             br_tag,
    output logic                         stall,
    input  logic                         mis_valid,
    input  logic [TAG_W-1:0]             mis_tag,
    output logic                         redirect_valid,
    output logic [PC_W-1:0]              redirect_pc,
    input  logic                         cmt_valid,
    input  logic [TAG_W-1:0]             cmt_tag,
    input  logic [AREG_W-1:0]            cmt_lookup_arch,
    output logic [PREG_W-1:0]            cmt_lookup_phys
);
    areg_t [GROUP_W-1:0] src_a_v, src_b_v, dst_arch_v;
    preg_t [GROUP_W-1:0] dst_phys_v, phys_a_v, phys_b_v;
    logic  [GROUP_W-1:0] byp_en, wr_en;
    logic                grp_fire, ck_push;
    map_t                map_after, restore_map;
    cnt_t                ck_count;
    tag_t                ck_head;

    assign src_a_v    = ren_src_a;
    assign src_b_v    = ren_src_b;
    assign dst_arch_v = ren_dst_arch;
    assign dst_phys_v = ren_dst_phys;
    assign src_a_phys = phys_a_v;
    assign src_b_phys = phys_b_v;

    // A group is taken only when the stack has room and no recovery is under way.
    assign grp_fire = (|ren_valid) && !stall && !mis_valid;
    assign ck_push  = grp_fire && ren_branch;

    for (genvar g = 0; g < GROUP_W; g++) begin : g_slot
        assign byp_en[g] = ren_valid[g] && ren_dst_valid[g] && (dst_arch_v[g] != '0);
        assign wr_en[g]  = byp_en[g] && grp_fire;
    end

    assign redirect_valid = mis_valid;

    rat_map_table u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .byp_en      (byp_en),
        .wr_en       (wr_en),
        .dst_arch    (dst_arch_v),
        .dst_phys    (dst_phys_v),
        .src_a       (src_a_v),
        .src_b       (src_b_v),
        .phys_a      (phys_a_v),
        .phys_b      (phys_b_v),
        .restore_en  (mis_valid),
        .restore_map (restore_map),
        .map_after   (map_after)
    );

    rat_ckpt_stack u_ck (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (ck_push),
        .push_map    (map_after),
        .push_pc     (ren_alt_pc),
        .mis_valid   (mis_valid),
        .mis_tag     (mis_tag),
        .cmt_valid   (cmt_valid),
        .cmt_tag     (cmt_tag),
        .cmt_arch    (cmt_lookup_arch),
        .cmt_phys    (cmt_lookup_phys),
        .restore_map (restore_map),
        .redirect_pc (redirect_pc),
        .alloc_tag   (br_tag),
        .full        (stall),
        .count_o     (ck_count),
        .head_o      (ck_head)
    );
endmodule

// File: rtl/rat_rename_map_chk.sv
module rat_rename_map_chk
    import rat_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      stall,
    input logic                      ck_push,
    input logic                      mis_valid,
    input logic [TAG_W-1:0]          mis_tag,
    input logic                      cmt_valid,
    input logic [TAG_W-1:0]          cmt_tag,
    input logic [TAG_W-1:0]          br_tag,
    input logic [CNT_W-1:0]          ck_count,
    input logic [TAG_W-1:0]          ck_head,
    input logic [GROUP_W*AREG_W-1:0] ren_src_a,
    input logic [GROUP_W*PREG_W-1:0] src_a_phys
);
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ck_count <= CNT_W'(CKPT_N));

    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !cmt_valid && !mis_valid |=> stall);

    a_r4_tag_order: assert property (@(posedge clk) disable iff (!rst_n)
        ck_push |=> br_tag == TAG_W'($past(br_tag) + 1'b1));

    a_r6_trim_younger: assert property (@(posedge clk) disable iff (!rst_n)
        mis_valid |=> br_tag == TAG_W'($past(mis_tag) + 1'b1));

    a_r7_commit_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |-> cmt_tag == ck_head && ck_count != '0);

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid && !mis_valid && !ck_push |=> ck_count == CNT_W'($past(ck_count) - 1'b1));

    for (genvar g = 0; g < GROUP_W; g++) begin : g_r0
        a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
            ren_src_a[g*AREG_W +: AREG_W] == '0 |-> src_a_phys[g*PREG_W +: PREG_W] == '0);
    end
endmodule

bind rat_rename_map rat_rename_map_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .ck_push    (ck_push),
    .mis_valid  (mis_valid),
    .mis_tag    (mis_tag),
    .cmt_valid  (cmt_valid),
    .cmt_tag    (cmt_tag),
    .br_tag     (br_tag),
    .ck_count   (ck_count),
    .ck_head    (ck_head),
    .ren_src_a  (ren_src_a),
    .src_a_phys (src_a_phys)
);

// File: tb/rat_rename_map_tb.sv
module rat_rename_map_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ren_valid = '0;
    logic [19:0] ren_src_a = '0, ren_src_b = '0, ren_dst_arch = '0;
    logic [3:0]  ren_dst_valid = '0;
    logic [27:0] ren_dst_phys = '0;
    logic        ren_branch = 1'b0;
    logic [31:0] ren_alt_pc = '0;
    logic [27:0] src_a_phys, src_b_phys;
    logic [1:0]  br_tag;
    logic        stall;
    logic        mis_valid = 1'b0;
    logic [1:0]  mis_tag = '0;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        cmt_valid = 1'b0;
    logic [1:0]  cmt_tag = '0;
    logic [4:0]  cmt_lookup_arch = '0;
    logic [6:0]  cmt_lookup_phys;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rat_rename_map u_dut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ren_valid = '0; ren_dst_valid = '0; ren_branch = 1'b0;
        ren_src_a = '0; ren_src_b = '0; ren_dst_arch = '0; ren_dst_phys = '0;
        mis_valid = 1'b0; cmt_valid = 1'b0;
    endtask

    task automatic slot(input int i, input int sa, input int sb, input bit dv,
                        input int da, input int dp);
        ren_valid[i] = 1'b1;
        ren_src_a[i*5 +: 5] = 5'(sa);
        ren_src_b[i*5 +: 5] = 5'(sb);
        ren_dst_valid[i] = dv;
        ren_dst_arch[i*5 +: 5] = 5'(da);
        ren_dst_phys[i*7 +: 7] = 7'(dp);
    endtask

    // Peek the current map through slot 0 with no valid group.
    task automatic peek(input string req, input int arch, input int exp);
        ren_src_a[4:0] = 5'(arch);
        #1 chk(req, src_a_phys[6:0], exp);
    endtask

    task automatic peek_cmt(input string req, input int arch, input int exp);
        cmt_lookup_arch = 5'(arch);
        #1 chk(req, cmt_lookup_phys, exp);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        peek("R1 map R1", 1, 1);
        peek("R1 map R31", 31, 31);
        peek_cmt("R1 cmt R17", 17, 17);
        chk("R1 stall", stall, 0);
        chk("R1 tag", br_tag, 0);
    endtask

    task automatic t_bypass();
        slot(0, 4, 5, 1, 2, 40);
        slot(1, 2, 7, 1, 2, 41);
        slot(2, 2, 2, 0, 0, 0);
        slot(3, 0, 9, 1, 0, 50);
        #2;
        chk("R2 slot0 reads old", src_a_phys[6:0], 4);
        chk("R2 slot1 bypass", src_a_phys[13:7], 40);
        chk("R2 slot2 youngest", src_a_phys[20:14], 41);
        chk("R2 slot2 srcb", src_b_phys[20:14], 41);
        chk("R9 slot3 reads zero", src_a_phys[27:21], 0);
        step();
        peek("R3 younger wins", 2, 41);
        peek("R9 write dropped", 0, 0);
    endtask

    task automatic t_branch_restore();
        slot(0, 1, 1, 1, 3, 60);
        ren_branch = 1'b1; ren_alt_pc = 32'h1000;
        #1 chk("R4 first tag", br_tag, 0);
        step();
        peek("R3 branch write", 3, 60);
        chk("R4 tag advanced", br_tag, 1);
        slot(0, 1, 1, 1, 3, 61);
        step();
        peek("R3 later write", 3, 61);
        mis_valid = 1'b1; mis_tag = 2'd0;
        #1;
        chk("R6 redirect valid", redirect_valid, 1);
        chk("R6 redirect pc", redirect_pc, 32'h1000);
        step();
        peek("R6 map restored", 3, 60);
        peek("R6 older kept", 2, 41);
        chk("R6 next tag", br_tag, 1);
    endtask

    task automatic t_fill();
        for (int k = 1; k <= 3; k++) begin
            slot(0, 1, 1, 1, 4, 80 + k);
            ren_branch = 1'b1; ren_alt_pc = 32'h2000 + 32'(4 * k);
            #1 chk("R4 tag sequence", br_tag, k);
            step();
        end
        chk("R5 stall full", stall, 1);
        slot(0, 1, 1, 1, 5, 70);
        ren_branch = 1'b1;
        step();
        peek("R5 rename ignored", 5, 5);
        chk("R5 still full", stall, 1);
        chk("R5 tag wrapped unchanged", br_tag, 0);
    endtask

    task automatic t_commit();
        cmt_valid = 1'b1; cmt_tag = 2'd0;
        step();
        peek_cmt("R7 commit tag0 R3", 3, 60);
        peek_cmt("R7 commit tag0 R2", 2, 41);
        peek_cmt("R7 commit tag0 R4", 4, 4);
        chk("R7 slot released", stall, 0);
        cmt_valid = 1'b1; cmt_tag = 2'd1;
        step();
        peek_cmt("R7 commit tag1 R4", 4, 81);
    endtask

    task automatic t_mis_with_rename();
        mis_valid = 1'b1; mis_tag = 2'd2;
        slot(0, 1, 1, 1, 6, 90);
        ren_branch = 1'b1; ren_alt_pc = 32'hDEAD;
        #1 chk("R6 redirect tag2", redirect_pc, 32'h2008);
        step();
        peek("R6 map from tag2", 4, 82);
        peek("R8 rename dropped", 6, 6);
        peek("R6 tag2 keeps R3", 3, 60);
        chk("R8 tag after drop", br_tag, 3);
        chk("R6 stall low", stall, 0);
    endtask

    task automatic t_zero();
        slot(0, 1, 1, 1, 0, 99);
        slot(1, 0, 0, 0, 0, 0);
        #1 chk("R9 no bypass to R0", src_a_phys[13:7], 0);
        step();
        peek("R9 R0 mapping", 0, 0);
        peek_cmt("R9 committed R0", 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_branch_restore();
        t_fill();
        t_commit();
        t_mis_with_rename();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule